// File: doc/BRIEF.md
# Register-Mapped SPI Master Core

This block is an SPI master that software drives through a 32-bit memory-mapped register port. Software writes words into a transmit FIFO and picks the clock polarity, clock phase and bit order in a control register. A transfer-inhibit bit holds the shift engine still, so several words can be queued before any clock edge appears. When the gate opens, the engine shifts the queued words out back to back on SCLK and MOSI. At the same time it samples MISO and places every word it receives into a receive FIFO, which software pops by reading the receive-data register.

Slave-select pins are active low. In manual mode they follow a software register at all times. In automatic mode the chosen line is asserted only while the engine is busy. A single-cycle `tx_done` pulse marks the moment the last queued word finishes shifting. The word width, the FIFO depth, the SCLK half-period (in system clocks) and the number of select lines are build-time parameters. Software cannot change them.

The shift engine is a three-state machine. `ST_IDLE` holds SCLK at the CPOL level. It moves to `ST_LEAD` when the gate is open and a word is queued, and pops that word at the same moment. `ST_LEAD` is the half period before the leading edge and moves to `ST_TRAIL` when its divider expires. `ST_TRAIL` is the half period with SCLK inverted. When its divider expires it returns to `ST_LEAD`, either for the next bit or, on a word boundary, for the next word if one is queued and the gate is still open. Otherwise it returns to `ST_IDLE`.

Top module: `spi_master_core`

## Requirements
- R1: After reset, the control register (offset 0x60) reads 0x100 (only inhibit set), the status register (0x64) reads 0x05, and the select register (0x70) reads all ones.
- R2: Control bit positions are: bit 1 enable, bit 2 master, bit 3 CPOL, bit 4 CPHA, bit 7 manual select, bit 8 inhibit, bit 9 LSB-first. A write followed by a read returns these bits unchanged.
- R3: Status bits are: bit 0 RX empty, bit 1 RX full, bit 2 TX empty, bit 3 TX full. Bit 4 (mode fault) always reads 0.
- R4: While inhibit is set, SCLK does not toggle even if the TX FIFO holds words. Once inhibit is cleared, all queued words shift out with no gap in slave select between them.
- R5: SCLK idles at the CPOL level. With CPHA=0 each bit is valid before the leading edge and is sampled on it. With CPHA=1 each bit is driven on the leading edge and sampled on the trailing edge.
- R6: With LSB-first clear, bit WORD_W-1 is sent first. With LSB-first set, bit 0 is sent first. Received bits are placed by the same rule.
- R7: Each word shifted pushes one received word into the RX FIFO. A read of offset 0x6C pops one word. A read while the RX FIFO is empty returns 0 and leaves the FIFO empty.
- R8: A write to the transmit-data register (0x68) while the TX FIFO is full is dropped.
- R9: Writing 1 to control bit 5 clears the TX FIFO, and writing 1 to bit 6 clears the RX FIFO. Both bits read back as 0.
- R10: In manual mode `ss_n` equals the select register. In automatic mode `ss_n` equals the select register only while words are shifting and is all ones otherwise.
- R11: `tx_done` pulses for one cycle when a word finishes and the TX FIFO is empty. The engine is idle in the following cycle.
- R12: Shifting needs both enable and master set. With either one clear, queued words stay queued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe (pops RX data at 0x6C) |
| bus_addr | input | 8 | Register byte offset |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the cycle of `bus_rd` |
| sclk | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| ss_n | output | NUM_SS | Active-low slave selects |
| tx_done | output | 1 | One-cycle pulse when the last queued word completes |

## Verification
The main stimulus is a table that covers all four CPOL/CPHA combinations, both bit orders, and a MISO loopback that is either straight or inverted. A bench monitor captures MOSI on the edge the mode defines as the sampling edge. A wrong phase therefore shows up as a shifted bit stream, a wrong order as a mirrored one, and a wrong receive assembly as a mismatched RX word. The inverted loopback separates genuine sampling of MISO from data that merely echoes the transmit register. Directed runs exercise the following cases:
- a three-word burst, to confirm there is no select gap and exactly one completion pulse;
- an overfull TX FIFO;
- reads of an empty RX FIFO;
- FIFO clears;
- the enable and master gates.

// File: rtl/spi_core_pkg.sv
package spi_core_pkg;

    localparam logic [7:0] OFS_CTRL = 8'h60;
    localparam logic [7:0] OFS_STAT = 8'h64;
    localparam logic [7:0] OFS_TXD  = 8'h68;
    localparam logic [7:0] OFS_RXD  = 8'h6C;
    localparam logic [7:0] OFS_SSEL = 8'h70;

    localparam int CB_EN     = 1;
    localparam int CB_MASTER = 2;
    localparam int CB_CPOL   = 3;
    localparam int CB_CPHA   = 4;
    localparam int CB_TXCLR  = 5;
    localparam int CB_RXCLR  = 6;
    localparam int CB_MANUAL = 7;
    localparam int CB_INHIB  = 8;
    localparam int CB_LSB    = 9;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_LEAD,
        ST_TRAIL
    } shift_state_t;

    typedef struct packed {
        logic lsb_first;
        logic inhibit;
        logic manual;
        logic cpha;
        logic cpol;
        logic master;
        logic en;
    } ctrl_t;

endpackage

// File: rtl/spi_word_fifo.sv
module spi_word_fifo #(
    parameter int W     = 8,
    parameter int DEPTH = 16
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       clr,
    input  logic                       push,
    input  logic [W-1:0]               din,
    input  logic                       pop,
    output logic [W-1:0]               dout,
    output logic [$clog2(DEPTH):0]     count,
    output logic                       empty,
    output logic                       full
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH) + 1;

    logic [W-1:0]  store [DEPTH];
    logic [AW-1:0] wr_ptr;
    logic [AW-1:0] rd_ptr;
    logic [CW-1:0] fill;
    logic          do_push;
    logic          do_pop;

    assign empty   = (fill == '0);
    assign full    = (fill == CW'(DEPTH));
    assign do_push = push && !full;
    assign do_pop  = pop && !empty;
    assign dout    = store[rd_ptr];
    assign count   = fill;

    function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
        return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            fill   <= '0;
        end else if (clr) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            fill   <= '0;
        end else begin
            if (do_push) wr_ptr <= bump(wr_ptr);
            if (do_pop)  rd_ptr <= bump(rd_ptr);
            unique case ({do_push, do_pop})
                2'b10:   fill <= fill + 1'b1;
                2'b01:   fill <= fill - 1'b1;
                default: fill <= fill;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (do_push && !clr) store[wr_ptr] <= din;
    end

endmodule

// File: rtl/spi_shift_engine.sv
module spi_shift_engine
    import spi_core_pkg::*;
#(
    parameter int W        = 8,
    parameter int HALF_DIV = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         run,
    input  logic         cpol,
    input  logic         cpha,
    input  logic         lsb_first,
    input  logic         tx_avail,
    input  logic [W-1:0] tx_word,
    input  logic         miso,
    output logic         tx_pop,
    output logic         rx_push,
    output logic [W-1:0] rx_word,
    output logic         sclk,
    output logic         mosi,
    output logic         busy,
    output logic         done
);
    localparam int BW = $clog2(W);
    localparam int DW = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;

    shift_state_t  state;
    shift_state_t  nxt;
    logic [DW-1:0] div_cnt;
    logic [BW-1:0] bit_cnt;
    logic [W-1:0]  sh_tx;
    logic [W-1:0]  sh_rx;
    logic          mosi_q;
    logic          half_end;
    logic          last_bit;
    logic          load;

    function automatic logic [BW-1:0] pick(input logic [BW-1:0] n, input logic lsb);
        return lsb ? n : (BW'(W - 1) - n);
    endfunction

    assign half_end = (div_cnt == DW'(HALF_DIV - 1));
    assign last_bit = (bit_cnt == BW'(W - 1));
    assign load     = ((state == ST_IDLE) && run && tx_avail) ||
                      ((state == ST_TRAIL) && half_end && last_bit && run && tx_avail);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    // transitions
    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE:  if (run && tx_avail) nxt = ST_LEAD;
            ST_LEAD:  if (half_end) nxt = ST_TRAIL;
            ST_TRAIL: begin
                if (half_end) begin
                    if (!last_bit)            nxt = ST_LEAD;
                    else if (run && tx_avail) nxt = ST_LEAD;
                    else                      nxt = ST_IDLE;
                end
            end
            default:  nxt = ST_IDLE;
        endcase
    end

    // datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            div_cnt <= '0;
            bit_cnt <= '0;
            sh_tx   <= '0;
            sh_rx   <= '0;
            mosi_q  <= 1'b0;
        end else begin
            if (state == ST_IDLE || half_end) div_cnt <= '0;
            else                              div_cnt <= div_cnt + 1'b1;

            if (state == ST_LEAD && half_end) begin
                if (!cpha) sh_rx[pick(bit_cnt, lsb_first)] <= miso;
                else       mosi_q <= sh_tx[pick(bit_cnt, lsb_first)];
            end

            if (state == ST_TRAIL && half_end) begin
                if (cpha) sh_rx[pick(bit_cnt, lsb_first)] <= miso;
                if (!last_bit) begin
                    bit_cnt <= bit_cnt + 1'b1;
                    if (!cpha) mosi_q <= sh_tx[pick(bit_cnt + 1'b1, lsb_first)];
                end
            end

            if (load) begin
                sh_tx   <= tx_word;
                bit_cnt <= '0;
                if (!cpha) mosi_q <= tx_word[pick('0, lsb_first)];
            end
        end
    end

    // outputs
    always_comb begin
        rx_word = sh_rx;
        if (cpha) rx_word[pick(bit_cnt, lsb_first)] = miso;
        rx_push = (state == ST_TRAIL) && half_end && last_bit;
        done    = rx_push && !tx_avail;
        tx_pop  = load;
        sclk    = (state == ST_TRAIL) ? ~cpol : cpol;
        mosi    = mosi_q;
        busy    = (state != ST_IDLE);
    end

endmodule

// File: rtl/spi_master_core.sv
module spi_master_core
    import spi_core_pkg::*;
#(
    parameter int WORD_W     = 8,
    parameter int FIFO_DEPTH = 16,
    parameter int HALF_DIV   = 2,
    parameter int NUM_SS     = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [7:0]        bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    output logic              sclk,
    output logic              mosi,
    input  logic              miso,
    output logic [NUM_SS-1:0] ss_n,
    output logic              tx_done
);
    localparam int CNT_W = $clog2(FIFO_DEPTH) + 1;

    ctrl_t              ctl;
    logic [NUM_SS-1:0]  ss_reg;
    logic               wr_ctrl;
    logic               wr_txd;
    logic               wr_ss;
    logic               rd_rxd;
    logic               tx_clr;
    logic               rx_clr;
    logic               run;
    logic               busy;
    logic               tx_pop;
    logic               rx_push;
    logic [WORD_W-1:0]  tx_dout;
    logic [WORD_W-1:0]  rx_dout;
    logic [WORD_W-1:0]  rx_word;
    logic [CNT_W-1:0]   tx_cnt;
    logic [CNT_W-1:0]   rx_cnt;
    logic               tx_empty;
    logic               tx_full;
    logic               rx_empty;
    logic               rx_full;
    logic               unused_wdata;

    assign wr_ctrl = bus_wr && (bus_addr == OFS_CTRL);
    assign wr_txd  = bus_wr && (bus_addr == OFS_TXD);
    assign wr_ss   = bus_wr && (bus_addr == OFS_SSEL);
    assign rd_rxd  = bus_rd && (bus_addr == OFS_RXD);
    assign tx_clr  = wr_ctrl && bus_wdata[CB_TXCLR];
    assign rx_clr  = wr_ctrl && bus_wdata[CB_RXCLR];
    assign run     = ctl.en && ctl.master && !ctl.inhibit;
    assign unused_wdata = ^bus_wdata;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl        <= '0;
            ctl.inhibit <= 1'b1;
            ss_reg     <= '1;
        end else begin
            if (wr_ctrl) begin
                ctl.en        <= bus_wdata[CB_EN];
                ctl.master    <= bus_wdata[CB_MASTER];
                ctl.cpol      <= bus_wdata[CB_CPOL];
                ctl.cpha      <= bus_wdata[CB_CPHA];
                ctl.manual    <= bus_wdata[CB_MANUAL];
                ctl.inhibit   <= bus_wdata[CB_INHIB];
                ctl.lsb_first <= bus_wdata[CB_LSB];
            end
            if (wr_ss) ss_reg <= bus_wdata[NUM_SS-1:0];
        end
    end

    spi_word_fifo #(.W(WORD_W), .DEPTH(FIFO_DEPTH)) u_txf (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (tx_clr),
        .push  (wr_txd),
        .din   (bus_wdata[WORD_W-1:0]),
        .pop   (tx_pop),
        .dout  (tx_dout),
        .count (tx_cnt),
        .empty (tx_empty),
        .full  (tx_full)
    );

    spi_word_fifo #(.W(WORD_W), .DEPTH(FIFO_DEPTH)) u_rxf (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (rx_clr),
        .push  (rx_push),
        .din   (rx_word),
        .pop   (rd_rxd),
        .dout  (rx_dout),
        .count (rx_cnt),
        .empty (rx_empty),
        .full  (rx_full)
    );

    spi_shift_engine #(.W(WORD_W), .HALF_DIV(HALF_DIV)) u_eng (
        .clk       (clk),
        .rst_n     (rst_n),
        .run       (run),
        .cpol      (ctl.cpol),
        .cpha      (ctl.cpha),
        .lsb_first (ctl.lsb_first),
        .tx_avail  (!tx_empty),
        .tx_word   (tx_dout),
        .miso      (miso),
        .tx_pop    (tx_pop),
        .rx_push   (rx_push),
        .rx_word   (rx_word),
        .sclk      (sclk),
        .mosi      (mosi),
        .busy      (busy),
        .done      (tx_done)
    );

    always_comb begin
        if (ctl.manual || busy) ss_n = ss_reg;
        else                    ss_n = '1;
    end

    always_comb begin
        bus_rdata = '0;
        unique case (bus_addr)
            OFS_CTRL: begin
                bus_rdata[CB_EN]     = ctl.en;
                bus_rdata[CB_MASTER] = ctl.master;
                bus_rdata[CB_CPOL]   = ctl.cpol;
                bus_rdata[CB_CPHA]   = ctl.cpha;
                bus_rdata[CB_MANUAL] = ctl.manual;
                bus_rdata[CB_INHIB]  = ctl.inhibit;
                bus_rdata[CB_LSB]    = ctl.lsb_first;
            end
            OFS_STAT: bus_rdata[3:0] = {tx_full, tx_empty, rx_full, rx_empty};
            OFS_RXD:  if (!rx_empty) bus_rdata = 32'(rx_dout);
            OFS_SSEL: bus_rdata = 32'(ss_reg);
            default:  bus_rdata = '0;
        endcase
    end

endmodule

// File: rtl/spi_master_core_chk.sv
module spi_master_core_chk
    import spi_core_pkg::*;
#(
    parameter int CNT_W = 5
) (
    input logic             clk,
    input logic             rst_n,
    input logic             bus_wr,
    input logic             bus_rd,
    input logic [7:0]       bus_addr,
    input logic [31:0]      bus_wdata,
    input logic             sclk,
    input logic             tx_done,
    input logic             busy,
    input logic             inhibit,
    input logic             tx_full,
    input logic             tx_pop,
    input logic             rx_empty,
    input logic             rx_push,
    input logic [CNT_W-1:0] tx_cnt,
    input logic [CNT_W-1:0] rx_cnt
);
    AST_INHIBIT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (inhibit && !busy && !(bus_wr && bus_addr == OFS_CTRL)) |=> $stable(sclk)); // R4

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == OFS_TXD && tx_full && !tx_pop) |=> $stable(tx_cnt)); // R8

    AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && bus_addr == OFS_RXD && rx_empty && !rx_push) |=> (rx_cnt == '0)); // R7

    AST_TX_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == OFS_CTRL && bus_wdata[CB_TXCLR]) |=> (tx_cnt == '0)); // R9

    AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        tx_done |=> !busy); // R11

endmodule

bind spi_master_core spi_master_core_chk #(.CNT_W(CNT_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_wr    (bus_wr),
    .bus_rd    (bus_rd),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .sclk      (sclk),
    .tx_done   (tx_done),
    .busy      (busy),
    .inhibit   (ctl.inhibit),
    .tx_full   (tx_full),
    .tx_pop    (tx_pop),
    .rx_empty  (rx_empty),
    .rx_push   (rx_push),
    .tx_cnt    (tx_cnt),
    .rx_cnt    (rx_cnt)
);

// File: tb/spi_master_core_test.sv
`timescale 1ns/1ps
module spi_master_core_test;
    localparam int DEPTH = 16;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0;
    logic        bus_rd = 1'b0;
    logic [7:0]  bus_addr = 8'h0;
    logic [31:0] bus_wdata = 32'h0;
    logic [31:0] bus_rdata;
    logic        sclk;
    logic        mosi;
    logic        miso;
    logic [3:0]  ss_n;
    logic        tx_done;
    logic        inv = 1'b0;

    int total = 0;
    int bad = 0;

    always #5 clk = ~clk;

    assign miso = mosi ^ inv;

    spi_master_core uut (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .sclk(sclk), .mosi(mosi), .miso(miso), .ss_n(ss_n), .tx_done(tx_done)
    );

    // MOSI monitor: captures on the sampling edge of the current mode
    logic        m_cpol = 1'b0;
    logic        m_cpha = 1'b0;
    logic [63:0] mon = '0;
    int          mon_n = 0;

    always @(sclk) begin
        if ((!m_cpha && (sclk != m_cpol)) || (m_cpha && (sclk == m_cpol))) begin
            mon = {mon[62:0], mosi};
            mon_n = mon_n + 1;
        end
    end

    // {cpol, cpha, lsb, inv, data[7:0]}
    localparam logic [11:0] VEC [8] = '{
        12'h0A5, 12'h43C, 12'h8C3, 12'hC5A,
        12'h2B1, 12'h61E, 12'h9F0, 12'hF81
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_rd = 1'b1; bus_addr = a;
        #1 d = bus_rdata;
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    function automatic logic [31:0] cw(input logic cpol, input logic cpha, input logic lsb,
                                       input logic inh, input logic man);
        return 32'h6 | (32'(cpol) << 3) | (32'(cpha) << 4) | (32'(man) << 7)
             | (32'(inh) << 8) | (32'(lsb) << 9);
    endfunction

    function automatic logic [7:0] rev8(input logic [7:0] v);
        logic [7:0] r;
        for (int i = 0; i < 8; i++) r[i] = v[7 - i];
        return r;
    endfunction

    task automatic wait_done(input string req);
        int n;
        n = 0;
        while (n < 5000) begin
            @(negedge clk);
            if (tx_done) break;
            n++;
        end
        if (n >= 5000) chk(req, 32'h0, 32'h1);
    endtask

    task automatic clear_mon();
        mon = '0;
        mon_n = 0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        bad++;
        total++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [31:0] d;
        int dones, rises, seen;
        logic [3:0] prev_ss;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 / R3 reset values
        rd(8'h60, d); chk("R1 ctrl reset", d, 32'h100);
        rd(8'h64, d); chk("R3 status reset", d, 32'h05);
        rd(8'h70, d); chk("R1 ssel reset", d, 32'hF);
        chk("R10 ss_n idle after reset", 32'(ss_n), 32'hF);

        // R2 / R9 control readback, reset bits read as zero
        wr(8'h60, 32'h3FE);
        rd(8'h60, d); chk("R2 R9 ctrl readback", d, 32'h39E);

        // table walk: R5 R6 R7
        wr(8'h70, 32'hE);
        for (int i = 0; i < 8; i++) begin
            logic [11:0] v;
            logic [7:0]  exp_bits;
            v = VEC[i];
            wr(8'h60, cw(v[11], v[10], v[9], 1'b1, 1'b0));
            m_cpol = v[11]; m_cpha = v[10]; inv = v[8];
            @(negedge clk);
            clear_mon();
            wr(8'h68, 32'(v[7:0]));
            wr(8'h60, cw(v[11], v[10], v[9], 1'b0, 1'b0));
            wait_done("R11 table done");
            wr(8'h60, cw(v[11], v[10], v[9], 1'b1, 1'b0));
            exp_bits = v[9] ? rev8(v[7:0]) : v[7:0];
            chk("R5 R6 mosi stream", {mon[7:0], 24'(mon_n)}, {exp_bits, 24'd8});
            rd(8'h6C, d);
            chk("R7 rx word", d, 32'(v[7:0] ^ {8{v[8]}}));
        end
        inv = 1'b0;
        m_cpol = 1'b0; m_cpha = 1'b0;
        wr(8'h60, cw(0, 0, 0, 1, 0));

        // R4 inhibit gate
        @(negedge clk); clear_mon();
        wr(8'h68, 32'hA5);
        repeat (60) @(negedge clk);
        chk("R4 no shift while inhibited", 32'(mon_n), 32'd0);
        rd(8'h64, d); chk("R3 tx not empty", 32'(d[2]), 32'd0);
        wr(8'h60, cw(0, 0, 0, 0, 0));
        wait_done("R4 release");
        chk("R4 shifted after release", 32'(mon_n), 32'd8);
        wr(8'h60, cw(0, 0, 0, 1, 0));
        rd(8'h6C, d);

        // R4 R10 R11 back-to-back burst, automatic select
        wr(8'h70, 32'hD);
        wr(8'h68, 32'h11); wr(8'h68, 32'h22); wr(8'h68, 32'h33);
        clear_mon();
        dones = 0; rises = 0; seen = 0;
        prev_ss = ss_n;
        wr(8'h60, cw(0, 0, 0, 0, 0));
        for (int c = 0; c < 300; c++) begin
            @(negedge clk);
            if (tx_done) dones++;
            if (ss_n == 4'hD) seen++;
            if (prev_ss == 4'hD && ss_n == 4'hF) rises++;
            prev_ss = ss_n;
        end
        chk("R11 one done pulse", 32'(dones), 32'd1);
        chk("R4 burst bits", 32'(mon_n), 32'd24);
        chk("R4 no select gap", 32'(rises), 32'd1);
        chk("R10 selected while shifting", 32'(seen > 0), 32'd1);
        chk("R10 released after burst", 32'(ss_n), 32'hF);
        wr(8'h60, cw(0, 0, 0, 1, 0));
        rd(8'h6C, d); chk("R7 burst first", d, 32'h11);
        rd(8'h6C, d); chk("R7 burst second", d, 32'h22);
        rd(8'h6C, d); chk("R7 burst third", d, 32'h33);
        rd(8'h6C, d); chk("R7 empty read zero", d, 32'h0);
        rd(8'h64, d); chk("R7 rx empty after drain", 32'(d[0]), 32'd1);

        // R10 manual select
        wr(8'h70, 32'hB);
        wr(8'h60, cw(0, 0, 0, 1, 1));
        @(negedge clk);
        chk("R10 manual mirror", 32'(ss_n), 32'hB);
        wr(8'h60, cw(0, 0, 0, 1, 0));
        @(negedge clk);
        chk("R10 auto idle", 32'(ss_n), 32'hF);

        // R8 overflow
        for (int k = 0; k <= DEPTH; k++) wr(8'h68, 32'(k));
        rd(8'h64, d); chk("R8 tx full", 32'(d[3:2]), 32'h2);
        wr(8'h60, cw(0, 0, 0, 0, 0));
        wait_done("R8 drain");
        wr(8'h60, cw(0, 0, 0, 1, 0));
        rd(8'h64, d); chk("R3 rx full", 32'(d[1:0]), 32'h2);
        for (int k = 0; k < DEPTH; k++) rd(8'h6C, d);
        chk("R8 last kept word", d, 32'(DEPTH - 1));
        rd(8'h64, d); chk("R8 extra word dropped", 32'(d[0]), 32'd1);

        // R9 FIFO clears
        wr(8'h68, 32'h5A); wr(8'h68, 32'h6B);
        wr(8'h60, cw(0, 0, 0, 1, 0) | 32'h20);
        rd(8'h64, d); chk("R9 tx cleared", 32'(d[2]), 32'd1);
        rd(8'h60, d); chk("R9 clear bits read zero", 32'(d[6:5]), 32'd0);
        wr(8'h68, 32'h77);
        wr(8'h60, cw(0, 0, 0, 0, 0));
        wait_done("R9 word");
        wr(8'h60, cw(0, 0, 0, 1, 0) | 32'h40);
        rd(8'h64, d); chk("R9 rx cleared", 32'(d[0]), 32'd1);
        chk("R3 mode fault zero", 32'(d[4]), 32'd0);

        // R12 enable / master gating
        clear_mon();
        wr(8'h68, 32'hC4);
        wr(8'h60, 32'h4);
        repeat (60) @(negedge clk);
        chk("R12 no shift without enable", 32'(mon_n), 32'd0);
        wr(8'h60, 32'h2);
        repeat (60) @(negedge clk);
        chk("R12 no shift without master", 32'(mon_n), 32'd0);
        wr(8'h60, 32'h6);
        wait_done("R12 enabled");
        chk("R12 shifts when both set", 32'(mon_n), 32'd8);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule